// File: doc/BRIEF.md
# Write-Only Serial Configuration Slave for a Video Crosspoint

This block is the control side of a 12-input, 9-output analog routing matrix. A host writes it over a two-wire serial bus in standard mode: a device address byte, a register pointer byte, then one or more data bytes. The block samples the clock and data lines with a faster system clock. It pulls the data line low through an open-drain enable to acknowledge each byte it accepts. The bus cannot read anything back from it.

Nine per-output control registers and two input-mode registers are decoded into steady configuration vectors for the analog side. Each output gets a one-hot input select, an amplifier enable, a two-bit gain step and a flag that ties the amplifier input to a fixed reference level. Each input gets a clamp-or-bias mode bit. Several outputs may listen to the same input. Powering an output down also drops its input selection.

Top module: `xpt_cfg_slave`

## Requirements
- R1: The slave acknowledges (sda_oe_o = 1 during the ninth clock high) only an address byte equal to 0x06 when addr_sel_i = 0, or 0x86 when addr_sel_i = 1. Any other address byte gets no acknowledge, and the bytes that follow it have no effect.
- R2: An address byte whose matching address has the R/W bit (bit 0) set to 1 is not acknowledged, and the slave ignores all bytes until the next START.
- R3: After an acknowledged address, the next byte is the register pointer and the byte after it is data; both are acknowledged. Registers 0x01..0x09 configure outputs 0..8 with bit 7 = enable, bits 6:5 = gain code on out_gain_o[2*o+:2], and bits 4:0 = input select code.
- R4: An enabled output with select code k in 1..12 drives exactly bit k-1 of its group out_sel_o[12*o+:12], and its out_ref_o[o] is 0.
- R5: An output whose enable bit is 0 drives an all-zero select group, whatever its code.
- R6: Select code 0 and codes 13..31 (any code with bit 4 set included) give an all-zero select group and out_ref_o[o] = 1, while out_en_o[o] still follows bit 7.
- R7: Register 0x1D bits 7:0 set in_clamp_o[7:0], and register 0x1E bits 3:0 set in_clamp_o[11:8]. Bits 7:4 of 0x1E are ignored. A 1 selects clamp and a 0 selects bias.
- R8: A write to any other register address is acknowledged and changes no output.
- R9: Data bytes after the first in one transaction go to successively incremented register addresses.
- R10: After reset every output is disabled with gain 0 and no selection, every out_ref_o bit is 1, every input is in bias mode, and sda_oe_o is 0.
- R11: A repeated START, with no STOP before it, restarts address matching.
- R12: Several outputs may select the same input at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| addr_sel_i | input | 1 | Selects address byte 0x06 (0) or 0x86 (1) |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| out_sel_o | output | 108 | One-hot input select, 12 bits per output, output 0 at the LSBs |
| out_en_o | output | 9 | Amplifier enable per output |
| out_gain_o | output | 18 | Gain code per output, 2 bits each |
| out_ref_o | output | 9 | Tie the amplifier input to the reference level |
| in_clamp_o | output | 12 | Per input: 1 = clamp, 0 = bias |

## Verification
Both bus lines pass through two synchronizer flops and one edge register. The acknowledge enable therefore rises about three system cycles after the eighth bus-clock falling edge. The bench samples it in the middle of the ninth clock-high phase, twelve cycles after that edge. A register write lands one cycle after the edge detector sees the falling edge that ends the eighth data bit, and the decoded vectors are combinational from the registers. The bench compares every output vector only after the STOP and one half bus period, which is well past that point. Each expected vector comes from a bench-side shadow of the written bytes that is decoded by the rules above.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CODE_W = 5;
  localparam int unsigned GAIN_W = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_DATA,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/xpt_line_sync.sv
module xpt_line_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
      prev_q <= '1;
    end else begin
      stg_q[0] <= line_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign level_o = stg_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/xpt_i2c_wr.sv
module xpt_i2c_wr
  import xpt_cfg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ADDR_BYTE = 8'h06,
  parameter logic [BYTE_W-1:0] ALT_MASK  = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic              addr_sel_i,
  output logic              ack_o,
  output logic              wr_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q, ptr_q, wr_addr_q, wr_data_q;
  logic              ack_q, wr_q;
  logic [BYTE_W-1:0] own_addr;
  logic              start_det, stop_det, active;

  assign own_addr  = ADDR_BYTE | (addr_sel_i ? ALT_MASK : '0);
  assign start_det = scl_lvl_i & sda_fall_i;
  assign stop_det  = scl_lvl_i & sda_rise_i;
  assign active    = (phase_q == PH_ADDR) || (phase_q == PH_PTR) || (phase_q == PH_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      ptr_q     <= '0;
      ack_q     <= 1'b0;
      wr_q      <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_q <= 1'b0;
      if (start_det) begin
        phase_q   <= PH_ADDR;
        bit_cnt_q <= '0;
        ack_q     <= 1'b0;
      end else if (stop_det) begin
        phase_q   <= PH_IDLE;
        bit_cnt_q <= '0;
        ack_q     <= 1'b0;
      end else if (active) begin
        if (scl_rise_i && bit_cnt_q < CNT_W'(BYTE_W)) begin
          shreg_q   <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end else if (scl_fall_i && bit_cnt_q == CNT_W'(BYTE_W)) begin
          if (ack_q) begin
            // end of the acknowledge clock
            ack_q     <= 1'b0;
            bit_cnt_q <= '0;
            if (phase_q == PH_ADDR)     phase_q <= PH_PTR;
            else if (phase_q == PH_PTR) phase_q <= PH_DATA;
          end else begin
            unique case (phase_q)
              PH_ADDR: begin
                if (shreg_q == own_addr) ack_q <= 1'b1;
                else                     phase_q <= PH_SKIP;
              end
              PH_PTR: begin
                ptr_q <= shreg_q;
                ack_q <= 1'b1;
              end
              PH_DATA: begin
                wr_q      <= 1'b1;
                wr_addr_q <= ptr_q;
                wr_data_q <= shreg_q;
                ptr_q     <= ptr_q + 1'b1;
                ack_q     <= 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign ack_o     = ack_q;
  assign wr_o      = wr_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;

  // R3
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_lvl_i && $past(scl_lvl_i) && !start_det && !stop_det) |-> $stable(ack_q));
  // R2
  skip_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SKIP) |-> (!ack_q && !wr_q));
  // R9
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> (ptr_q == wr_addr_q + 1'b1));
endmodule

// File: rtl/xpt_cfg_regs.sv
module xpt_cfg_regs
  import xpt_cfg_pkg::*;
#(
  parameter int unsigned       NUM_IN     = 12,
  parameter int unsigned       NUM_OUT    = 9,
  parameter logic [BYTE_W-1:0] CLAMP_BASE = 8'h1D
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [BYTE_W-1:0]          addr_i,
  input  logic [BYTE_W-1:0]          data_i,
  output logic [NUM_OUT*NUM_IN-1:0]  sel_o,
  output logic [NUM_OUT-1:0]         en_o,
  output logic [NUM_OUT*GAIN_W-1:0]  gain_o,
  output logic [NUM_OUT-1:0]         ref_o,
  output logic [NUM_IN-1:0]          clamp_o
);
  localparam int unsigned CLAMP_REGS = (NUM_IN + BYTE_W - 1) / BYTE_W;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [BYTE_W-1:0] cfg_q;
    logic [CODE_W-1:0] code;
    logic              valid;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cfg_q <= '0;
      else if (wr_i && addr_i == BYTE_W'(o + 1))    cfg_q <= data_i;
    end

    assign code  = cfg_q[CODE_W-1:0];
    assign valid = (code != '0) && (code <= CODE_W'(NUM_IN));
    assign en_o[o]                  = cfg_q[BYTE_W-1];
    assign gain_o[GAIN_W*o +: GAIN_W] = cfg_q[BYTE_W-2 -: GAIN_W];
    assign ref_o[o]                 = ~valid;
    assign sel_o[NUM_IN*o +: NUM_IN] = (valid && cfg_q[BYTE_W-1]) ?
                                       (NUM_IN'(1) << (code - 1'b1)) : '0;

    // R4
    sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(sel_o[NUM_IN*o +: NUM_IN]));
    // R5
    off_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_o[o] |-> (sel_o[NUM_IN*o +: NUM_IN] == '0));
    // R6
    ref_nosel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_o[o] |-> (sel_o[NUM_IN*o +: NUM_IN] == '0));
  end

  for (genvar b = 0; b < NUM_IN; b++) begin : g_clamp
    localparam int unsigned REG_IDX = b / BYTE_W;
    localparam int unsigned BIT_IDX = b % BYTE_W;
    logic mode_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q <= 1'b0;
      else if (wr_i && addr_i == CLAMP_BASE + BYTE_W'(REG_IDX)) mode_q <= data_i[BIT_IDX];
    end
    assign clamp_o[b] = mode_q;
  end

  logic known_addr;
  assign known_addr = (addr_i >= BYTE_W'(1) && addr_i <= BYTE_W'(NUM_OUT)) ||
                      (addr_i >= CLAMP_BASE && addr_i < CLAMP_BASE + BYTE_W'(CLAMP_REGS));

  // R8
  undef_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !known_addr) |=> $stable({sel_o, en_o, gain_o, ref_o, clamp_o}));
endmodule

// File: rtl/xpt_cfg_slave.sv
module xpt_cfg_slave
  import xpt_cfg_pkg::*;
#(
  parameter int unsigned       NUM_IN     = 12,
  parameter int unsigned       NUM_OUT    = 9,
  parameter int unsigned       SYNC_STG   = 2,
  parameter logic [BYTE_W-1:0] ADDR_BYTE  = 8'h06,
  parameter logic [BYTE_W-1:0] ALT_MASK   = 8'h80,
  parameter logic [BYTE_W-1:0] CLAMP_BASE = 8'h1D
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic                       addr_sel_i,
  output logic                       sda_oe_o,
  output logic [NUM_OUT*NUM_IN-1:0]  out_sel_o,
  output logic [NUM_OUT-1:0]         out_en_o,
  output logic [NUM_OUT*GAIN_W-1:0]  out_gain_o,
  output logic [NUM_OUT-1:0]         out_ref_o,
  output logic [NUM_IN-1:0]          in_clamp_o
);
  logic [1:0]        lvl, rise, fall;
  logic              wr;
  logic [BYTE_W-1:0] wr_addr, wr_data;

  xpt_line_sync #(.W(2), .STAGES(SYNC_STG)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  ({scl_i, sda_i}),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  xpt_i2c_wr #(.ADDR_BYTE(ADDR_BYTE), .ALT_MASK(ALT_MASK)) i_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_lvl_i  (lvl[1]),
    .scl_rise_i (rise[1]),
    .scl_fall_i (fall[1]),
    .sda_lvl_i  (lvl[0]),
    .sda_rise_i (rise[0]),
    .sda_fall_i (fall[0]),
    .addr_sel_i (addr_sel_i),
    .ack_o      (sda_oe_o),
    .wr_o       (wr),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  xpt_cfg_regs #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .CLAMP_BASE(CLAMP_BASE)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .addr_i  (wr_addr),
    .data_i  (wr_data),
    .sel_o   (out_sel_o),
    .en_o    (out_en_o),
    .gain_o  (out_gain_o),
    .ref_o   (out_ref_o),
    .clamp_o (in_clamp_o)
  );
endmodule

// File: tb/test_xpt_cfg_slave.sv
module test_xpt_cfg_slave;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1, addr_sel = 1'b0;
  logic sda_oe, sda_w;
  logic [107:0] sel;
  logic [8:0]   en, refl;
  logic [17:0]  gain;
  logic [11:0]  clamp;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;
  logic [7:0]  cfg_m [9];
  logic [11:0] clamp_m;

  always #10 clk = ~clk;
  assign sda_w = sda_drv & ~sda_oe;

  xpt_cfg_slave i_xpt_cfg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_w), .addr_sel_i(addr_sel),
    .sda_oe_o(sda_oe), .out_sel_o(sel), .out_en_o(en), .out_gain_o(gain),
    .out_ref_o(refl), .in_clamp_o(clamp)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hp();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; hp(); scl = 1'b1; hp(); sda_drv = 1'b0; hp(); scl = 1'b0; hp();
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; hp(); scl = 1'b1; hp(); sda_drv = 1'b1; hp();
  endtask

  task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
    logic ack;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; hp(); scl = 1'b1; hp(); scl = 1'b0;
    end
    sda_drv = 1'b1; hp(); scl = 1'b1;
    repeat (Q/2) @(negedge clk);
    ack = sda_oe;
    repeat (Q/2) @(negedge clk);
    scl = 1'b0;
    check({tag, " ack"}, 128'(ack), 128'(exp_ack));
  endtask

  function automatic void apply(input logic [7:0] p, input logic [7:0] d);
    if (p >= 8'd1 && p <= 8'd9) cfg_m[p-1] = d;
    else if (p == 8'h1D) clamp_m[7:0] = d;
    else if (p == 8'h1E) clamp_m[11:8] = d[3:0];
  endfunction

  task automatic check_all(input string tag);
    logic [107:0] e_sel = '0;
    logic [8:0]   e_en, e_ref;
    logic [17:0]  e_gain;
    for (int o = 0; o < 9; o++) begin
      int code = int'(cfg_m[o][4:0]);
      logic v = (code >= 1) && (code <= 12);
      e_en[o] = cfg_m[o][7];
      e_gain[2*o +: 2] = cfg_m[o][6:5];
      e_ref[o] = ~v;
      if (v && cfg_m[o][7]) e_sel[12*o + code - 1] = 1'b1;
    end
    hp();
    check({tag, " sel"},   128'(sel),   128'(e_sel));
    check({tag, " en"},    128'(en),    128'(e_en));
    check({tag, " gain"},  128'(gain),  128'(e_gain));
    check({tag, " ref"},   128'(refl),  128'(e_ref));
    check({tag, " clamp"}, 128'(clamp), 128'(clamp_m));
  endtask

  task automatic wr_reg(input logic [7:0] p, input logic [7:0] d, input string tag);
    i2c_start();
    send(addr_sel ? 8'h86 : 8'h06, 1'b1, tag);
    send(p, 1'b1, tag);
    send(d, 1'b1, tag);
    i2c_stop();
    apply(p, d);
  endtask

  task automatic t_reset();
    check("R10 sda_oe", 128'(sda_oe), 128'(0));
    check_all("R10 reset");
  endtask

  task automatic t_route();
    wr_reg(8'h01, 8'hA3, "R3 route");
    wr_reg(8'h04, 8'hCC, "R4 route");
    check_all("R4 route");
  endtask

  task automatic t_disable();
    wr_reg(8'h02, 8'h0C, "R5 disable");
    check_all("R5 disabled");
    wr_reg(8'h02, 8'h8C, "R5 enable");
    check_all("R5 reenabled");
  endtask

  task automatic t_off();
    wr_reg(8'h07, 8'h80, "R6 code0");
    wr_reg(8'h08, 8'hED, "R6 code13");
    wr_reg(8'h09, 8'h9F, "R6 code31");
    wr_reg(8'h01, 8'h90, "R6 code16");
    check_all("R6 off codes");
  endtask

  task automatic t_clamp();
    wr_reg(8'h1D, 8'h5A, "R7 lo");
    wr_reg(8'h1E, 8'hFC, "R7 hi");
    check_all("R7 clamp");
  endtask

  task automatic t_undef();
    wr_reg(8'h00, 8'hFF, "R8 a00");
    wr_reg(8'h0A, 8'hFF, "R8 a0A");
    wr_reg(8'h1C, 8'hFF, "R8 a1C");
    wr_reg(8'h1F, 8'hFF, "R8 a1F");
    check_all("R8 undefined");
  endtask

  task automatic t_autoinc();
    i2c_start();
    send(8'h06, 1'b1, "R9 dev");
    send(8'h04, 1'b1, "R9 ptr");
    send(8'h84, 1'b1, "R9 d0"); apply(8'h04, 8'h84);
    send(8'hC6, 1'b1, "R9 d1"); apply(8'h05, 8'hC6);
    send(8'h2C, 1'b1, "R9 d2"); apply(8'h06, 8'h2C);
    i2c_stop();
    check_all("R9 burst");
    i2c_start();
    send(8'h06, 1'b1, "R9 dev2");
    send(8'h1D, 1'b1, "R9 ptr2");
    send(8'hAA, 1'b1, "R9 c0"); apply(8'h1D, 8'hAA);
    send(8'hF7, 1'b1, "R9 c1"); apply(8'h1E, 8'hF7);
    i2c_stop();
    check_all("R9 R7 clamp burst");
  endtask

  task automatic t_addr();
    i2c_start();
    send(8'h86, 1'b0, "R1 wrong addr");
    send(8'h01, 1'b0, "R1 ptr ignored");
    send(8'hFF, 1'b0, "R1 data ignored");
    i2c_stop();
    check_all("R1 wrong addr");
    addr_sel = 1'b1;
    wr_reg(8'h02, 8'h83, "R1 alt addr");
    check_all("R1 alt addr");
    i2c_start();
    send(8'h06, 1'b0, "R1 base off");
    i2c_stop();
    addr_sel = 1'b0;
  endtask

  task automatic t_read();
    i2c_start();
    send(8'h07, 1'b0, "R2 read");
    send(8'h01, 1'b0, "R2 ptr");
    send(8'h81, 1'b0, "R2 data");
    i2c_stop();
    check_all("R2 read ignored");
  endtask

  task automatic t_restart();
    i2c_start();
    send(8'h07, 1'b0, "R11 read");
    i2c_start();
    send(8'h06, 1'b1, "R11 dev");
    send(8'h03, 1'b1, "R11 ptr");
    send(8'hA5, 1'b1, "R11 data");
    i2c_stop();
    apply(8'h03, 8'hA5);
    check_all("R11 restart");
  endtask

  task automatic t_many();
    wr_reg(8'h01, 8'h81, "R12 o1");
    wr_reg(8'h05, 8'h81, "R12 o5");
    wr_reg(8'h09, 8'hC1, "R12 o9");
    check_all("R12 fanout");
  endtask

  initial begin
    for (int o = 0; o < 9; o++) cfg_m[o] = '0;
    clamp_m = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    hp();
    t_reset();
    t_route();
    t_disable();
    t_off();
    t_clamp();
    t_undef();
    t_autoinc();
    t_addr();
    t_read();
    t_restart();
    t_many();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule